// File: doc/BRIEF.md
# Clock Bank Disable Controller

This block gates one bank of identical clock outputs. A single disable request and a three-valued mode selector decide the bank's state. When the disable is low, every output of the bank carries the source clock. When it is high, the bank either stops cleanly at logic low or releases its pads to high impedance, depending on the mode. A test mode overrides the disable request and keeps the bank running.

The disable request may arrive with no timing relation to the clock. It is passed through a short synchroniser in the clock domain. The resulting run/stop decision is registered on the falling clock edge, so the gated outputs can never produce a shortened high phase, neither when stopping nor when resuming. The output-enable for the bank's tri-state pads is a purely combinational function of the raw disable and the mode, so the high-impedance path does not wait for any clock.

Top module: `clkbank_disable`

## Requirements
- R1: While `rst_ni` is low, every bit of `q_o` is held low, including during the clock's high phase.
- R2: With `dis_i` low and the mode 2'b00 (hold-off style) or 2'b10 (tri-state style), every bit of `q_o` follows `clk_i` and `oe_o` is 1.
- R3: With `dis_i` high and the mode 2'b10, `oe_o` drops to 0 in the same time step, with no clock edge needed. The data outputs keep carrying the clock behind the disabled pads.
- R4: With `dis_i` high and the mode 2'b00, every bit of `q_o` is held low and `oe_o` stays 1.
- R5: The internal run/stop decision changes only while `clk_i` is low. As a result, no high phase of `q_o` is ever cut short.
- R6: After `dis_i` rises in mode 2'b00, the outputs are stopped within at most 6 clock cycles.
- R7: With the mode 2'b01 (test), `dis_i` has no effect: `q_o` follows the clock and `oe_o` is 1.
- R8: After a hold-off ends, the outputs resume within at most 6 cycles, and the first pulse is a full-width high phase.
- R9: All `NUM_OUT` bits of `q_o` always carry the same value.
- R10: The unused mode code 2'b11 behaves exactly like 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock to be distributed by the bank |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dis_i | input | 1 | Bank disable request, asynchronous to `clk_i` |
| mode_i | input | 2 | Mode: 00 hold-off, 01 test, 10 tri-state, 11 tri-state |
| q_o | output | NUM_OUT | Gated clock outputs of the bank |
| oe_o | output | 1 | Output-enable for the bank's tri-state pads |

## Verification
The assertions watch, on every change, that the run/stop decision moves only while the clock is low. On every rising edge they check that a hold-off request stops the bank within the six-cycle budget, that the bank restarts within the same budget once the request ends, and that test mode never lets the bank stop. Other behaviour is only visible through the bench's scenarios:
- the combinational release of the pads within one time step in tri-state mode,
- the pulse widths seen at the output pins,
- the handling of the spare mode code,
- the low outputs during reset.

// File: rtl/bankdis_pkg.sv
package bankdis_pkg;

    typedef enum logic [1:0] {
        BM_HOLD    = 2'b00,
        BM_TEST    = 2'b01,
        BM_TRI     = 2'b10,
        BM_TRI_ALT = 2'b11
    } bank_mode_e;

    typedef struct packed {
        logic holdoff_sel;
        logic tri_sel;
        logic test_sel;
    } mode_dec_s;

endpackage

// File: rtl/bankdis_sync.sv
module bankdis_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/bankdis_mode.sv
module bankdis_mode
    import bankdis_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       dis_i,
    output mode_dec_s  dec_o,
    output logic       oe_o
);

    always_comb begin
        dec_o = '0;
        unique case (bank_mode_e'(mode_i))
            BM_HOLD:            dec_o.holdoff_sel = 1'b1;
            BM_TEST:            dec_o.test_sel    = 1'b1;
            BM_TRI, BM_TRI_ALT: dec_o.tri_sel     = 1'b1;
            default:            dec_o             = '0;
        endcase
    end

    // Pads release at once: raw request, no clock on this path.
    assign oe_o = !(dis_i && dec_o.tri_sel);

endmodule

// File: rtl/bankdis_gate.sv
module bankdis_gate #(
    parameter int NUM_OUT = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               stop_req_i,
    input  logic               test_i,
    output logic               run_o,
    output logic [NUM_OUT-1:0] q_o
);

    typedef struct packed {
        logic run;
    } gate_s;

    gate_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (test_i) st_d.run = 1'b1;
        else        st_d.run = !stop_req_i;
    end

    // Falling-edge register: the enable only changes while the clock is low.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o = st_q.run;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        assign q_o[g] = clk_i & st_q.run;
    end

endmodule

// File: rtl/clkbank_disable.sv
module clkbank_disable
    import bankdis_pkg::*;
#(
    parameter int NUM_OUT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               dis_i,
    input  logic [1:0]         mode_i,
    output logic [NUM_OUT-1:0] q_o,
    output logic               oe_o
);

    mode_dec_s dec_w;
    logic      dis_sync_w;
    logic      stop_req_w;
    logic      run_w;

    bankdis_mode u_mode (
        .mode_i (mode_i),
        .dis_i  (dis_i),
        .dec_o  (dec_w),
        .oe_o   (oe_o)
    );

    bankdis_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (dis_i),
        .sync_o  (dis_sync_w)
    );

    assign stop_req_w = dis_sync_w && dec_w.holdoff_sel;

    bankdis_gate #(.NUM_OUT(NUM_OUT)) u_gate (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stop_req_i (stop_req_w),
        .test_i     (dec_w.test_sel),
        .run_o      (run_w),
        .q_o        (q_o)
    );

endmodule

// File: rtl/bankdis_chk.sv
module bankdis_chk #(
    parameter int BUDGET = 6
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       dis_i,
    input logic [1:0] mode_i,
    input logic       run
);

    localparam int CW = $clog2(BUDGET + 1) + 1;

    logic [CW-1:0] off_cnt, on_cnt;
    logic          hold_req;

    assign hold_req = dis_i && (mode_i == 2'b00);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            off_cnt <= '0;
            on_cnt  <= '0;
        end else begin
            if (!hold_req)                       off_cnt <= '0;
            else if (off_cnt < CW'(BUDGET))      off_cnt <= off_cnt + 1'b1;
            if (hold_req)                        on_cnt  <= '0;
            else if (on_cnt < CW'(BUDGET))       on_cnt  <= on_cnt + 1'b1;
        end
    end

    // R5: the enable register moves only in the clock's low phase
    always @(run) begin
        if (rst_ni) begin
            a_r5_gate_moves_low: assert (!clk_i)
                else $error("run changed while clock high");
        end
    end

    a_r6_stop_in_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (off_cnt >= CW'(BUDGET)) |-> !run);

    a_r8_resume_in_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (on_cnt >= CW'(BUDGET)) |-> run);

    a_r7_test_keeps_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b01 && $past(mode_i) == 2'b01 && $past(rst_ni)) |-> run);

endmodule

bind clkbank_disable bankdis_chk #(.BUDGET(6)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dis_i  (dis_i),
    .mode_i (mode_i),
    .run    (run_w)
);

// File: tb/tb_clkbank_disable.sv
`timescale 1ns/1ps
module tb_clkbank_disable;

    localparam int N = 4;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         dis_i = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic [N-1:0] q_o;
    logic         oe_o;

    int total = 0;
    int bad   = 0;

    clkbank_disable #(.NUM_OUT(N)) dut (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .dis_i  (dis_i),
        .mode_i (mode_i),
        .q_o    (q_o),
        .oe_o   (oe_o)
    );

    always #5 clk_i = ~clk_i;

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // {mode[1:0], dis, exp_oe, exp_high_phase}
    localparam logic [4:0] VEC [10] = '{
        {2'b00, 1'b0, 1'b1, 1'b1},   // R2
        {2'b10, 1'b0, 1'b1, 1'b1},   // R2
        {2'b00, 1'b1, 1'b1, 1'b0},   // R4
        {2'b10, 1'b1, 1'b0, 1'b1},   // R3
        {2'b01, 1'b1, 1'b1, 1'b1},   // R7
        {2'b01, 1'b0, 1'b1, 1'b1},   // R7
        {2'b11, 1'b1, 1'b0, 1'b1},   // R10
        {2'b11, 1'b0, 1'b1, 1'b1},   // R10
        {2'b00, 1'b1, 1'b1, 1'b0},   // R4
        {2'b00, 1'b0, 1'b1, 1'b1}    // R2
    };

    function automatic string tag_of(input logic [1:0] m, input logic d);
        if (m == 2'b01) return "R7";
        if (m == 2'b11) return "R10";
        if (!d)         return "R2";
        if (m == 2'b10) return "R3";
        return "R4";
    endfunction

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a, b;
        int   first;
        // R1: outputs low during reset, even in the high phase
        repeat (2) @(posedge clk_i);
        #2;
        check(q_o == '0, "R1", 8'(q_o), 8'h0);
        @(negedge clk_i); #1 rst_ni = 1'b1;

        // vector table
        foreach (VEC[i]) begin
            mode_i = VEC[i][4:3];
            dis_i  = VEC[i][2];
            repeat (5) @(posedge clk_i);
            #2;
            check(oe_o == VEC[i][1], tag_of(VEC[i][4:3], VEC[i][2]), 8'(oe_o), 8'(VEC[i][1]));
            check(q_o == {N{VEC[i][0]}}, tag_of(VEC[i][4:3], VEC[i][2]), 8'(q_o), {N{VEC[i][0]}});
            check(q_o == '0 || q_o == '1, "R9", 8'(q_o), 8'(q_o[0] ? '1 : '0));
            @(negedge clk_i); #2;
            check(q_o == '0, tag_of(VEC[i][4:3], VEC[i][2]), 8'(q_o), 8'h0);
        end

        // R3: pads release within the same low phase, no edge needed
        mode_i = 2'b10; dis_i = 1'b0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i); #1 dis_i = 1'b1;
        #1 check(oe_o == 1'b0, "R3", 8'(oe_o), 8'h0);
        #1 dis_i = 1'b0;
        #1 check(oe_o == 1'b1, "R3", 8'(oe_o), 8'h1);

        // R5/R6: hold-off entry, full pulses only, within budget
        mode_i = 2'b00;
        repeat (4) @(posedge clk_i);
        #1 dis_i = 1'b1;
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk_i); #1 a = q_o[0]; #3 b = q_o[0];
            check(a == b, "R5", 8'(b), 8'(a));
            if (!a && first == 0) first = k;
        end
        check(first >= 1 && first <= 6, "R6", 8'(first), 8'd6);

        // R8: resume within budget, first pulse full width
        #1 dis_i = 1'b0;
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk_i); #1 a = q_o[0]; #3 b = q_o[0];
            check(a == b, "R8", 8'(b), 8'(a));
            if (a && first == 0) first = k;
        end
        check(first >= 1 && first <= 6, "R8", 8'(first), 8'd6);

        // R7: toggling disable in test mode never stops the bank
        mode_i = 2'b01;
        repeat (3) @(posedge clk_i);
        for (int k = 0; k < 8; k++) begin
            #1 dis_i = ~dis_i;
            @(posedge clk_i); #2;
            check(q_o == '1 && oe_o, "R7", 8'({oe_o, q_o}), 8'({1'b1, {N{1'b1}}}));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule